// File: doc/BRIEF.md
# Configurable Serial Transceiver with Byte-Split Divisor

This block is an asynchronous serial transmitter and receiver behind a small register interface. Software picks the character length (5 to 8 bits), one or two stop bits and the parity mode (none, even or odd) while the block runs. Bit timing comes from a 16-bit divisor that is written as two separate byte registers. A free-running counter divides the system clock by the divisor to make an oversampling tick, and each bit on the line lasts 16 of those ticks.

Each direction has one holding register in front of its shift register. Software can load the next character while the current one is on the line, and the receiver can take in a new character while the previous one waits to be read. A maskable transmit-empty interrupt and a maskable receive-ready interrupt tell software when to act. The receiver records parity, framing and overrun errors in sticky flags that are cleared by reading the status register.

Register map, selected by `addr`: 0 holds data (a write loads the transmit holding register, a read returns the received character). 1 is control: bits [1:0] set the length as code+5, bit 2 selects two stop bits, bits [4:3] set parity (01 even, 10 odd, 00 or 11 none), bit 5 enables the transmit interrupt and bit 6 enables the receive interrupt. 2 is the divisor low byte and 3 the divisor high byte. 4 is status: bit 0 means a received character is waiting, bit 1 means the transmit holding register is empty, bit 2 means the transmitter is fully idle, bit 3 is the parity error flag, bit 4 the framing error flag and bit 5 the overrun flag. Reads return data in the same cycle.

Top module: `uart_core`

## Requirements
- R1: After reset, `txd` is high, both interrupts are low, status reads 0x06, control reads 0x03 (8 data bits, one stop bit, no parity, interrupts off) and the divisor reads as low byte 0x01 and high byte 0x00.
- R2: Every bit on `txd` lasts exactly 16 × D system clocks, where D = {high byte, low byte} of the divisor registers, and both bytes read back as written.
- R3: A divisor of zero behaves as 65536, so each bit lasts 1,048,576 clocks.
- R4: A transmitted frame is one low start bit, then the data bits least significant first (only the low 5..8 bits of the written byte, per control bits [1:0]), then optional parity, then the stop bits high. The line idles high.
- R5: The parity bit makes the count of ones over data and parity even in even mode (control [4:3] = 01) or odd in odd mode (10). The receiver checks it by the same rule.
- R6: Control bit 2 set sends two high stop bits and clear sends one. The receiver checks only the first stop bit.
- R7: A written character moves from the holding register to the shifter within one oversampling tick if the shifter is idle. Status bit 1 then reads 1 while the frame is still going out, and a second character written meanwhile is sent right after the first.
- R8: A received character sets status bit 0 at the middle of its first stop bit. A data read returns it with the unused upper bits zero and clears status bit 0.
- R9: A received parity bit that breaks the selected rule sets status bit 3.
- R10: A first stop bit sampled low sets status bit 4, and the character is still delivered.
- R11: A character that completes while status bit 0 is still set sets status bit 5 and replaces the unread character.
- R12: A status read clears bits 3, 4 and 5 on the following edge, unless a character completes on that same edge. Bit 0 is left unchanged.
- R13: `irq_tx` equals control bit 5 AND an empty transmit holding register. `irq_rx` equals control bit 6 AND status bit 0.
- R14: A low pulse on `rxd` that has ended before the middle of the start bit starts no reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| addr | input | 3 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| irq_tx | output | 1 | Transmit holding register empty interrupt |
| irq_rx | output | 1 | Received character interrupt |

## Verification
A write reaches the shifter on the next tick (at most D clocks), and `txd` changes one edge after that. The bench therefore does not predict the start edge: it finds the falling edge at a negative clock edge and samples every later bit at its middle, k·16·D + 8·D clocks on. On the receive side, the result is due about half a bit plus the two synchroniser flops after the stop bit begins. The bench reads status only after driving a whole stop bit, and for a bad stop bit it waits two further bit times so that the rejected false start has also ended. Register reads are sampled one nanosecond after the negative edge on which the strobe is raised, and their clearing effects are checked by a second read.

// File: rtl/uart_core.sv
module uart_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       irq_tx,
  output logic       irq_rx
);

  localparam logic [2:0] A_DATA = 3'd0, A_CTRL = 3'd1, A_DLO = 3'd2, A_DHI = 3'd3, A_STAT = 3'd4;

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_state_t;

  logic [6:0]  ctrl;
  logic [7:0]  dlo, dhi;
  logic [15:0] bcnt;
  logic        tick;

  logic        wr_tx, rd_rx, rd_st;
  logic [3:0]  nbits;
  logic        par_en, par_odd, stop2;

  logic [7:0]  thr;
  logic        thr_full, tx_busy, tx_load;
  logic [11:0] tsh, tframe;
  logic [3:0]  trem, tcnt, tflen;
  logic        tpar;

  logic        rs1, rs2;
  rx_state_t   rstate;
  logic [3:0]  rcnt;
  logic [2:0]  ridx;
  logic [7:0]  rsh, rbr;
  logic        rpar, rx_ready, perr, ferr, ovr;
  logic        rx_done, rpar_bad;

  assign wr_tx = wr_en && addr == A_DATA;
  assign rd_rx = rd_en && addr == A_DATA;
  assign rd_st = rd_en && addr == A_STAT;

  assign nbits   = 4'd5 + {2'b00, ctrl[1:0]};
  assign stop2   = ctrl[2];
  assign par_en  = ctrl[3] ^ ctrl[4];
  assign par_odd = ctrl[4];

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= 7'h03;
      dlo  <= 8'h01;
      dhi  <= 8'h00;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  ctrl <= wdata[6:0];
        A_DLO:   dlo  <= wdata;
        A_DHI:   dhi  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_DATA:  rdata = rbr;
      A_CTRL:  rdata = {1'b0, ctrl};
      A_DLO:   rdata = dlo;
      A_DHI:   rdata = dhi;
      A_STAT:  rdata = {2'b00, ovr, ferr, perr, !tx_busy && !thr_full, !thr_full, rx_ready};
      default: rdata = 8'h00;
    endcase
  end

  // oversampling tick: a divisor of zero wraps to 65536
  assign tick = (bcnt == 16'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= 16'd0;
    else        bcnt <= tick ? ({dhi, dlo} - 16'd1) : (bcnt - 16'd1);
  end

  // transmit path
  always_comb begin
    tframe    = '1;
    tframe[0] = 1'b0;
    tpar      = par_odd;
    for (int i = 0; i < 8; i++) begin
      if (4'(i) < nbits) begin
        tframe[i + 1] = thr[i];
        tpar          = tpar ^ thr[i];
      end
    end
    if (par_en) tframe[nbits + 4'd1] = tpar;
  end

  assign tflen   = 4'd2 + nbits + {3'b000, par_en} + {3'b000, stop2};
  assign tx_load = tick && !tx_busy && thr_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr      <= 8'h00;
      thr_full <= 1'b0;
    end else begin
      if (tx_load) thr_full <= 1'b0;
      if (wr_tx) begin
        thr      <= wdata;
        thr_full <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tsh     <= '1;
      trem    <= 4'd0;
      tcnt    <= 4'd0;
    end else if (tx_load) begin
      tx_busy <= 1'b1;
      tsh     <= tframe;
      trem    <= tflen;
      tcnt    <= 4'd0;
    end else if (tick && tx_busy) begin
      tcnt <= tcnt + 4'd1;
      if (tcnt == 4'd15) begin
        tsh  <= {1'b1, tsh[11:1]};
        trem <= trem - 4'd1;
        if (trem == 4'd1) tx_busy <= 1'b0;
      end
    end
  end

  assign txd = tx_busy ? tsh[0] : 1'b1;

  // receive path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rs1, rs2} <= 2'b11;
    else        {rs1, rs2} <= {rxd, rs1};
  end

  assign rx_done  = tick && rstate == R_STOP && rcnt == 4'd15;
  assign rpar_bad = par_en && ((^rsh) ^ rpar ^ par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstate <= R_IDLE;
      rcnt   <= 4'd0;
      ridx   <= 3'd0;
      rsh    <= 8'h00;
      rpar   <= 1'b0;
    end else if (tick) begin
      case (rstate)
        R_IDLE: if (!rs2) begin
          rstate <= R_START;
          rcnt   <= 4'd0;
        end
        R_START: begin
          if (rcnt == 4'd7) begin
            if (!rs2) begin
              rstate <= R_DATA;
              rcnt   <= 4'd0;
              ridx   <= 3'd0;
              rsh    <= 8'h00;
            end else rstate <= R_IDLE;
          end else rcnt <= rcnt + 4'd1;
        end
        R_DATA: begin
          rcnt <= rcnt + 4'd1;
          if (rcnt == 4'd15) begin
            rsh[ridx] <= rs2;
            if ({1'b0, ridx} == nbits - 4'd1) rstate <= par_en ? R_PAR : R_STOP;
            else ridx <= ridx + 3'd1;
          end
        end
        R_PAR: begin
          rcnt <= rcnt + 4'd1;
          if (rcnt == 4'd15) begin
            rpar   <= rs2;
            rstate <= R_STOP;
          end
        end
        R_STOP: begin
          rcnt <= rcnt + 4'd1;
          if (rcnt == 4'd15) rstate <= R_IDLE;
        end
        default: rstate <= R_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr      <= 8'h00;
      rx_ready <= 1'b0;
      perr     <= 1'b0;
      ferr     <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      if (rd_st) {perr, ferr, ovr} <= 3'b000;
      if (rd_rx) rx_ready <= 1'b0;
      if (rx_done) begin
        rbr      <= rsh;
        rx_ready <= 1'b1;
        if (rpar_bad) perr <= 1'b1;
        if (!rs2) ferr <= 1'b1;
        if (rx_ready && !rd_rx) ovr <= 1'b1;
      end
    end
  end

  assign irq_tx = ctrl[5] && !thr_full;
  assign irq_rx = ctrl[6] && rx_ready;

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n) tx_load |=> (tx_busy && !txd)); // R4
  AST_TX_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (tx_busy && !(tick && tcnt == 4'd15)) |=> $stable(txd)); // R2
  AST_THR_DRAINS: assert property (@(posedge clk) disable iff (!rst_n) (tx_load && !wr_tx) |=> !thr_full); // R7
  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_rx && !rx_done) |=> !rx_ready); // R8
  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_st && !rx_done) |=> !(perr || ferr || ovr)); // R12
  AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n) (rx_done && rx_ready && !rd_rx) |=> ovr); // R11

endmodule

// File: tb/test_uart_core.sv
`timescale 1ns/1ps
module test_uart_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       txd, irq_tx, irq_rx;
  logic       rxd = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  int div_v = 1;

  always #2 clk = ~clk;

  uart_core i_uart_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string tag);
    logic [7:0] v;
    rd(a, v);
    chk(tag, int'(v), exp);
  endtask

  function automatic logic [7:0] mkctrl(input int len, input bit s2, input int par, input bit tie, input bit rie);
    logic [1:0] pc;
    pc = (par == 1) ? 2'b01 : (par == 2) ? 2'b10 : 2'b00;
    return {1'b0, rie, tie, pc, s2, 2'(len - 5)};
  endfunction

  // par: 0 none, 1 even, 2 odd
  function automatic void mkframe(input logic [7:0] d, input int len, input int par, input bit s2,
                                  output logic [15:0] bits, output int n);
    bit p;
    bits = '1;
    bits[0] = 1'b0;
    p = (par == 2);
    n = 1;
    for (int i = 0; i < len; i++) begin
      bits[n] = d[i];
      p = p ^ d[i];
      n++;
    end
    if (par != 0) begin
      bits[n] = p;
      n++;
    end
    n = n + (s2 ? 2 : 1);
  endfunction

  task automatic wait_fall(input int limit, output bit seen);
    seen = 1'b0;
    for (int t = 0; t < limit; t++) begin
      @(negedge clk);
      if (txd === 1'b0) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic expect_tx(input logic [7:0] d, input int len, input int par, input bit s2, input string tag);
    logic [15:0] exp_bits, got;
    int n, bp;
    bit seen;
    mkframe(d, len, par, s2, exp_bits, n);
    bp = 16 * div_v;
    wait_fall(20 * bp, seen);
    got = '1;
    for (int k = 0; k < n; k++) begin
      repeat (k == 0 ? bp / 2 : bp) @(negedge clk);
      got[k] = txd;
    end
    if (!seen) got = 16'h0000;
    chk(tag, int'(got & 16'((1 << n) - 1)), int'(exp_bits & 16'((1 << n) - 1)));
  endtask

  task automatic drive_rx(input logic [7:0] d, input int len, input int par, input bit s2,
                          input bit badp, input bit bads);
    logic [15:0] bits;
    int n, bp, sidx;
    mkframe(d, len, par, s2, bits, n);
    bp = 16 * div_v;
    sidx = 1 + len + (par != 0 ? 1 : 0);
    if (badp) bits[sidx - 1] = ~bits[sidx - 1];
    if (bads) bits[sidx] = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rxd = bits[k];
      repeat ((bads && k == sidx) ? (bp * 3) / 4 - 1 : bp - 1) @(negedge clk);
    end
    @(negedge clk);
    rxd = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 txd idle", int'(txd), 1);
    chk("R1 irq_tx", int'(irq_tx), 0);
    chk("R1 irq_rx", int'(irq_rx), 0);
    rd_chk(3'd4, 8'h06, "R1 status");
    rd_chk(3'd1, 8'h03, "R1 control");
    rd_chk(3'd2, 8'h01, "R1 divisor low");
    rd_chk(3'd3, 8'h00, "R1 divisor high");

    div_v = 2;
    wr(3'd2, 8'h02);
    wr(3'd1, mkctrl(8, 0, 0, 1, 1));
    @(negedge clk);
    chk("R13 irq_tx enabled and empty", int'(irq_tx), 1);

    // R4, R7: back-to-back characters
    fork
      begin
        expect_tx(8'hA5, 8, 0, 0, "R4 R7 first frame 8N1");
        expect_tx(8'h5A, 8, 0, 0, "R7 second frame follows");
      end
      begin
        wr(3'd0, 8'hA5);
        repeat (4) @(negedge clk);
        rd_chk(3'd4, 8'h02, "R7 holding empty while shifting");
        wr(3'd0, 8'h5A);
        chk("R13 irq_tx low when holding full", int'(irq_tx), 0);
        rd_chk(3'd4, 8'h00, "R7 holding full while busy");
      end
    join
    repeat (64) @(negedge clk);
    rd_chk(3'd4, 8'h06, "R4 idle after frames");

    // R5 even parity, 7 bits
    wr(3'd1, mkctrl(7, 0, 1, 1, 1));
    fork
      expect_tx(8'h53, 7, 1, 0, "R5 even parity 7 bits");
      wr(3'd0, 8'h53);
    join
    repeat (64) @(negedge clk);

    // R5 odd parity, R6 two stop bits
    wr(3'd1, mkctrl(6, 1, 2, 1, 1));
    fork
      expect_tx(8'h2D, 6, 2, 1, "R5 R6 odd parity two stops");
      wr(3'd0, 8'h2D);
    join
    repeat (64) @(negedge clk);

    // R4 length masking at 5 bits
    wr(3'd1, mkctrl(5, 0, 0, 1, 1));
    fork
      expect_tx(8'hFF, 5, 0, 0, "R4 five bit frame");
      wr(3'd0, 8'hFF);
    join
    repeat (64) @(negedge clk);

    // R8 reception
    wr(3'd1, mkctrl(8, 0, 0, 1, 1));
    drive_rx(8'h3C, 8, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk("R13 irq_rx on ready", int'(irq_rx), 1);
    rd_chk(3'd4, 8'h07, "R8 ready flag");
    rd_chk(3'd0, 8'h3C, "R8 data");
    rd_chk(3'd4, 8'h06, "R8 ready cleared by read");
    chk("R13 irq_rx cleared", int'(irq_rx), 0);

    // R8 R5 six bits odd parity, good parity, upper bits zero
    wr(3'd1, mkctrl(6, 0, 2, 1, 1));
    drive_rx(8'hED, 6, 2, 0, 0, 0);
    repeat (4) @(negedge clk);
    rd_chk(3'd0, 8'h2D, "R8 masked six bit data");
    rd_chk(3'd4, 8'h06, "R5 good odd parity no error");

    // R9 parity error, R12 clear on status read
    wr(3'd1, mkctrl(7, 0, 1, 1, 1));
    drive_rx(8'h41, 7, 1, 0, 1, 0);
    repeat (4) @(negedge clk);
    rd_chk(3'd4, 8'h0F, "R9 parity error flag");
    rd_chk(3'd4, 8'h07, "R12 parity flag cleared, ready kept");
    rd_chk(3'd0, 8'h41, "R9 data kept");

    // R10 framing error
    wr(3'd1, mkctrl(8, 0, 0, 1, 1));
    drive_rx(8'h81, 8, 0, 0, 0, 1);
    repeat (64) @(negedge clk);
    rd_chk(3'd4, 8'h17, "R10 framing error flag");
    rd_chk(3'd0, 8'h81, "R10 data delivered");
    rd_chk(3'd4, 8'h06, "R12 framing flag cleared");

    // R11 overrun
    drive_rx(8'h11, 8, 0, 0, 0, 0);
    drive_rx(8'h22, 8, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    rd_chk(3'd4, 8'h27, "R11 overrun flag");
    rd_chk(3'd0, 8'h22, "R11 newest data kept");
    rd_chk(3'd4, 8'h06, "R12 overrun flag cleared");

    // R14 short low pulse
    @(negedge clk);
    rxd = 1'b0;
    repeat (3 * div_v) @(negedge clk);
    rxd = 1'b1;
    repeat (64) @(negedge clk);
    rd_chk(3'd4, 8'h06, "R14 glitch ignored");
    chk("R14 no irq_rx", int'(irq_rx), 0);

    // R13 masked interrupts
    wr(3'd1, mkctrl(8, 0, 0, 0, 0));
    @(negedge clk);
    chk("R13 irq_tx masked", int'(irq_tx), 0);
    drive_rx(8'h55, 8, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk("R13 irq_rx masked", int'(irq_rx), 0);
    rd_chk(3'd0, 8'h55, "R8 data with interrupts masked");

    // R2 divisor from both bytes: 0x0100
    wr(3'd3, 8'h01);
    wr(3'd2, 8'h00);
    div_v = 256;
    rd_chk(3'd3, 8'h01, "R2 divisor high readback");
    rd_chk(3'd2, 8'h00, "R2 divisor low readback");
    fork
      begin
        wait_fall(2000, seen);
        cnt = 0;
        while (seen && txd === 1'b0 && cnt < 10000) begin
          cnt++;
          @(negedge clk);
        end
        chk("R2 bit length 16 x 256", cnt, 4096);
      end
      wr(3'd0, 8'h01);
    join
    repeat (9 * 4096 + 512) @(negedge clk);
    rd_chk(3'd4, 8'h06, "R2 frame complete");

    // R3 divisor zero acts as 65536
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    fork
      begin
        wait_fall(70000, seen);
        chk("R3 start bit begins", int'(seen), 1);
        repeat (20000) @(negedge clk);
        chk("R3 start bit still low", int'(txd), 0);
      end
      wr(3'd0, 8'h00);
    join

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule